// File: doc/BRIEF.md
# Nearest-Frequency Clock Setting Search Engine

This block searches a clock generator's setting space for the setting whose output frequency comes closest to a requested target in Hz. A source frequency is chosen first. In fixed mode there are two fixed sources. In programmable mode the source is a PLL fed by a 24 MHz reference, with a multiplier, a pre-divider and a post-shift. Every source is then followed by an odd divider and a power-of-two shift. The engine visits every combination in a fixed order. It computes each candidate's output with rounded division and keeps the first setting that has the smallest absolute error.

Software or a sequencer loads the target, the divider limit and the mode, then pulses `start`. When `done` pulses, the engine has settled the best fields, the achieved frequency and two packed words: a control byte and a PLL word. All divisions use one shared shift-subtract divider that produces one quotient bit per cycle, so the engine needs no wide combinational divider.

Top module: `clk_setting_search`

## Requirements
- R1: In fixed mode (`prog_mode`=0) the sources are FIX_A_HZ (288 MHz) and then FIX_B_HZ (336 MHz), in that order.
- R2: In programmable mode the source is floor(24,000,000 × M / N) shifted right by K. M runs from M_MIN to M_MAX (outer loop), N runs from N_MIN to N_MAX, and K runs over 0 and 1 (inner loop). The defaults are 2..255 for M and 2..127 for N.
- R3: A candidate's output is floor((src + D/2) / D) with D = div << shift, and its error is |output − target|.
- R4: The odd divider takes the values 1, 3 and 5 in that order, with 5 allowed only when `max_div5`=1. For each divider, shift takes the values 0 to 7.
- R5: The best error starts at 999,999,999, and a candidate replaces the best only when its error is strictly smaller, so the first setting wins a tie. `best_err` reports the final error.
- R6: `achieved_hz` equals floor(best_src / (div << shift)).
- R7: In programmable mode `pll_word` = 0x20000 | K<<15 | N<<8 | M. In fixed mode it is 0.
- R8: `ctrl_byte` bits [2:0] hold the shift. Bit 3 is set for divider 3 and bit 4 for divider 5. Bit 5 is set when the 336 MHz fixed source wins. Bit 6 is set in programmable mode.
- R9: A `start` in idle raises `busy` in the next cycle. A `start` while busy is ignored. `done` is a one-cycle pulse, and `busy` is low in that same cycle.
- R10: After reset all outputs are 0. The result outputs change only in the cycle `done` is high and hold otherwise, including through the next search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (taken only in idle) |
| target_hz | input | 32 | Requested frequency in Hz |
| max_div5 | input | 1 | 1: odd divider up to 5; 0: up to 3 |
| prog_mode | input | 1 | 1: PLL sweep; 0: two fixed sources |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| best_mul | output | 8 | Winning M (0 in fixed mode) |
| best_prediv | output | 7 | Winning N (0 in fixed mode) |
| best_post | output | 1 | Winning K (0 in fixed mode) |
| best_odd_div | output | 3 | Winning odd divider 1, 3 or 5 |
| best_shift | output | 3 | Winning shift 0..7 |
| best_err | output | SRC_W | Error of the winning candidate |
| achieved_hz | output | SRC_W | Truncated achieved frequency |
| ctrl_byte | output | 8 | Packed control byte |
| pll_word | output | 32 | Packed PLL word |

## Verification
The bench keeps the default fixed sources, reference and divider width, but narrows the PLL sweep to M in 2..6 and N in 2..4. A programmable search then takes about 26 thousand cycles instead of millions. That range still reaches exact hits, K=1 halving and ties between different (M, N) pairs, and every vector in both modes is compared against a reference search written in the bench.

// File: rtl/clk_search_pkg.sv
package clk_search_pkg;

  localparam int MUL_W = 8;
  localparam int PRE_W = 7;
  localparam longint ERR_INIT = 64'd999999999;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SRC, ST_SRC_WAIT, ST_CAND, ST_CAND_WAIT,
    ST_NEXT, ST_FIN, ST_FIN_WAIT
  } srch_state_t;

  function automatic logic [2:0] odd_div_of(input logic [1:0] idx);
    case (idx)
      2'd0:    odd_div_of = 3'd1;
      2'd1:    odd_div_of = 3'd3;
      default: odd_div_of = 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/clk_div_unit.sv
module clk_div_unit #(
  parameter int DW = 34
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quotient,
  output logic          done
);
  localparam int CW = $clog2(DW + 1);

  logic [DW:0]   rem_q;
  logic [DW-1:0] quo_q;
  logic [DW-1:0] dsr_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [DW:0]   shifted;
  logic          fits;

  always_comb begin
    shifted = {rem_q[DW-1:0], quo_q[DW-1]};
    fits    = shifted >= {1'b0, dsr_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? (shifted - {1'b0, dsr_q}) : shifted;
        quo_q <= {quo_q[DW-2:0], fits};
        if (cnt_q == CW'(DW - 1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;

  // R3: a finished division leaves a remainder below the divisor
  assert_rem_below_div_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (rem_q < {1'b0, dsr_q}));

  // R9: the sequencer never restarts a division in flight
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    start |-> !run_q);

endmodule

// File: rtl/clk_src_iter.sv
module clk_src_iter
  import clk_search_pkg::*;
#(
  parameter int M_MIN = 2,
  parameter int M_MAX = 255,
  parameter int N_MIN = 2,
  parameter int N_MAX = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             step,
  input  logic             prog,
  output logic [MUL_W-1:0] cur_m,
  output logic [PRE_W-1:0] cur_n,
  output logic             cur_k,
  output logic             cur_fix,
  output logic             is_last
);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      cur_m   <= MUL_W'(M_MIN);
      cur_n   <= PRE_W'(N_MIN);
      cur_k   <= 1'b0;
      cur_fix <= 1'b0;
    end else if (step) begin
      if (!prog) begin
        cur_fix <= 1'b1;
      end else if (!cur_k) begin
        cur_k <= 1'b1;
      end else begin
        cur_k <= 1'b0;
        if (cur_n == PRE_W'(N_MAX)) begin
          cur_n <= PRE_W'(N_MIN);
          cur_m <= cur_m + 1'b1;
        end else begin
          cur_n <= cur_n + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (prog)
      is_last = (cur_m == MUL_W'(M_MAX)) && (cur_n == PRE_W'(N_MAX)) && cur_k;
    else
      is_last = cur_fix;
  end

  // R2: the sweep stays inside its configured M and N ranges
  assert_sweep_range_R2: assert property (@(posedge clk) disable iff (rst)
    (cur_m >= MUL_W'(M_MIN)) && (cur_m <= MUL_W'(M_MAX)) &&
    (cur_n >= PRE_W'(N_MIN)) && (cur_n <= PRE_W'(N_MAX)));

endmodule

// File: rtl/clk_best_track.sv
module clk_best_track
  import clk_search_pkg::*;
#(
  parameter int SRC_W = 34
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic [SRC_W-1:0] cand_err,
  input  logic [SRC_W-1:0] cand_src,
  input  logic [MUL_W-1:0] cand_m,
  input  logic [PRE_W-1:0] cand_n,
  input  logic             cand_k,
  input  logic             cand_fix,
  input  logic [1:0]       cand_didx,
  input  logic [2:0]       cand_shift,
  output logic [SRC_W-1:0] best_err,
  output logic [SRC_W-1:0] best_src,
  output logic [MUL_W-1:0] best_m,
  output logic [PRE_W-1:0] best_n,
  output logic             best_k,
  output logic             best_fix,
  output logic [1:0]       best_didx,
  output logic [2:0]       best_shift
);
  logic better;
  assign better = cand_err < best_err;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      best_err   <= SRC_W'(ERR_INIT);
      best_src   <= '0;
      best_m     <= '0;
      best_n     <= '0;
      best_k     <= 1'b0;
      best_fix   <= 1'b0;
      best_didx  <= 2'd0;
      best_shift <= 3'd0;
    end else if (upd && better) begin
      best_err   <= cand_err;
      best_src   <= cand_src;
      best_m     <= cand_m;
      best_n     <= cand_n;
      best_k     <= cand_k;
      best_fix   <= cand_fix;
      best_didx  <= cand_didx;
      best_shift <= cand_shift;
    end
  end

  // R5: between clears the kept error never grows
  assert_best_monotone_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> (best_err <= $past(best_err)));

endmodule

// File: rtl/clk_setting_search.sv
module clk_setting_search
  import clk_search_pkg::*;
#(
  parameter int     SRC_W     = 34,
  parameter longint REF_HZ    = 24000000,
  parameter longint FIX_A_HZ  = 288000000,
  parameter longint FIX_B_HZ  = 336000000,
  parameter int     M_MIN     = 2,
  parameter int     M_MAX     = 255,
  parameter int     N_MIN     = 2,
  parameter int     N_MAX     = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [31:0]      target_hz,
  input  logic             max_div5,
  input  logic             prog_mode,
  output logic             busy,
  output logic             done,
  output logic [7:0]       best_mul,
  output logic [6:0]       best_prediv,
  output logic             best_post,
  output logic [2:0]       best_odd_div,
  output logic [2:0]       best_shift,
  output logic [SRC_W-1:0] best_err,
  output logic [SRC_W-1:0] achieved_hz,
  output logic [7:0]       ctrl_byte,
  output logic [31:0]      pll_word
);
  localparam logic [SRC_W-1:0] REF_V = SRC_W'(REF_HZ);
  localparam logic [SRC_W-1:0] FIX_A = SRC_W'(FIX_A_HZ);
  localparam logic [SRC_W-1:0] FIX_B = SRC_W'(FIX_B_HZ);

  srch_state_t      state_q;
  logic [31:0]      tgt_q;
  logic             mode_q, mx5_q;
  logic [SRC_W-1:0] src_q, pll_quot_q;
  logic [1:0]       didx_q;
  logic [2:0]       shift_q;

  logic [MUL_W-1:0] it_m;
  logic [PRE_W-1:0] it_n;
  logic             it_k, it_fix, it_last;
  logic             it_init, it_step;

  logic             dv_start, dv_done;
  logic [SRC_W-1:0] dv_a, dv_b, dv_q;

  logic [SRC_W-1:0] bt_err, bt_src;
  logic [MUL_W-1:0] bt_m;
  logic [PRE_W-1:0] bt_n;
  logic             bt_k, bt_fix;
  logic [1:0]       bt_didx;
  logic [2:0]       bt_shift;

  logic [9:0]       cand_dv, best_dv;
  logic [SRC_W-1:0] cand_err, tgt_ext;
  logic             cand_upd;
  logic [1:0]       last_didx;

  assign it_init   = (state_q == ST_IDLE) && start;
  assign it_step   = (state_q == ST_NEXT) && !it_last;
  assign cand_dv   = 10'(odd_div_of(didx_q)) << shift_q;
  assign best_dv   = 10'(odd_div_of(bt_didx)) << bt_shift;
  assign tgt_ext   = SRC_W'(tgt_q);
  assign cand_err  = (dv_q >= tgt_ext) ? (dv_q - tgt_ext) : (tgt_ext - dv_q);
  assign cand_upd  = (state_q == ST_CAND_WAIT) && dv_done;
  assign last_didx = mx5_q ? 2'd2 : 2'd1;

  always_comb begin
    dv_start = 1'b0;
    dv_a     = '0;
    dv_b     = SRC_W'(1);
    case (state_q)
      ST_SRC: if (mode_q && !it_k) begin
        dv_start = 1'b1;
        dv_a     = REF_V * SRC_W'(it_m);
        dv_b     = SRC_W'(it_n);
      end
      ST_CAND: begin
        dv_start = 1'b1;
        dv_a     = src_q + SRC_W'(cand_dv >> 1);
        dv_b     = SRC_W'(cand_dv);
      end
      ST_FIN: begin
        dv_start = 1'b1;
        dv_a     = bt_src;
        dv_b     = SRC_W'(best_dv);
      end
      default: ;
    endcase
  end

  clk_src_iter #(.M_MIN(M_MIN), .M_MAX(M_MAX), .N_MIN(N_MIN), .N_MAX(N_MAX)) u_iter (
    .clk(clk), .rst(rst), .init(it_init), .step(it_step), .prog(mode_q),
    .cur_m(it_m), .cur_n(it_n), .cur_k(it_k), .cur_fix(it_fix), .is_last(it_last)
  );

  clk_div_unit #(.DW(SRC_W)) u_div (
    .clk(clk), .rst(rst), .start(dv_start), .dividend(dv_a), .divisor(dv_b),
    .quotient(dv_q), .done(dv_done)
  );

  clk_best_track #(.SRC_W(SRC_W)) u_best (
    .clk(clk), .rst(rst), .clr(it_init), .upd(cand_upd),
    .cand_err(cand_err), .cand_src(src_q),
    .cand_m(mode_q ? it_m : '0), .cand_n(mode_q ? it_n : '0),
    .cand_k(mode_q & it_k), .cand_fix(it_fix),
    .cand_didx(didx_q), .cand_shift(shift_q),
    .best_err(bt_err), .best_src(bt_src), .best_m(bt_m), .best_n(bt_n),
    .best_k(bt_k), .best_fix(bt_fix), .best_didx(bt_didx), .best_shift(bt_shift)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      tgt_q        <= '0;
      mode_q       <= 1'b0;
      mx5_q        <= 1'b0;
      src_q        <= '0;
      pll_quot_q   <= '0;
      didx_q       <= 2'd0;
      shift_q      <= 3'd0;
      done         <= 1'b0;
      best_mul     <= '0;
      best_prediv  <= '0;
      best_post    <= 1'b0;
      best_odd_div <= '0;
      best_shift   <= '0;
      best_err     <= '0;
      achieved_hz  <= '0;
      ctrl_byte    <= '0;
      pll_word     <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          tgt_q   <= target_hz;
          mode_q  <= prog_mode;
          mx5_q   <= max_div5;
          state_q <= ST_SRC;
        end
        ST_SRC: begin
          didx_q  <= 2'd0;
          shift_q <= 3'd0;
          if (!mode_q) begin
            src_q   <= it_fix ? FIX_B : FIX_A;
            state_q <= ST_CAND;
          end else if (it_k) begin
            src_q   <= pll_quot_q >> 1;
            state_q <= ST_CAND;
          end else begin
            state_q <= ST_SRC_WAIT;
          end
        end
        ST_SRC_WAIT: if (dv_done) begin
          pll_quot_q <= dv_q;
          src_q      <= dv_q;
          state_q    <= ST_CAND;
        end
        ST_CAND: state_q <= ST_CAND_WAIT;
        ST_CAND_WAIT: if (dv_done) begin
          if (shift_q == 3'd7) begin
            shift_q <= 3'd0;
            if (didx_q == last_didx) begin
              state_q <= ST_NEXT;
            end else begin
              didx_q  <= didx_q + 1'b1;
              state_q <= ST_CAND;
            end
          end else begin
            shift_q <= shift_q + 1'b1;
            state_q <= ST_CAND;
          end
        end
        ST_NEXT: state_q <= it_last ? ST_FIN : ST_SRC;
        ST_FIN:  state_q <= ST_FIN_WAIT;
        ST_FIN_WAIT: if (dv_done) begin
          achieved_hz  <= dv_q;
          best_err     <= bt_err;
          best_mul     <= bt_m;
          best_prediv  <= bt_n;
          best_post    <= bt_k;
          best_odd_div <= odd_div_of(bt_didx);
          best_shift   <= bt_shift;
          ctrl_byte    <= {1'b0, mode_q, (!mode_q && bt_fix),
                           (bt_didx == 2'd2), (bt_didx == 2'd1), bt_shift};
          pll_word     <= mode_q ? (32'h20000 | (32'(bt_k) << 15) |
                                    (32'(bt_n) << 8) | 32'(bt_m)) : 32'd0;
          done         <= 1'b1;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: the latched request cannot change mid-search
  assert_request_held_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(tgt_q) && $stable(mode_q) && $stable(mx5_q));

  // R8: never both divider flags at once
  assert_ctrl_one_div_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !(ctrl_byte[3] && ctrl_byte[4]));

  // R7: programmable result carries the enable bit and a legal M; fixed gives zero
  assert_pll_word_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (mode_q ? (pll_word[17] && (pll_word[7:0] >= 8'(M_MIN))) : (pll_word == 32'd0)));

  // R10: results move only together with done
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ctrl_byte) && $stable(pll_word) && $stable(achieved_hz) && $stable(best_err));

endmodule

// File: tb/clk_setting_search_tb.sv
module clk_setting_search_tb;
  localparam int SW = 34;
  localparam int MMIN = 2, MMAX = 6, NMIN = 2, NMAX = 4;
  localparam int NV = 10;

  localparam logic [31:0] V_TGT [NV] = '{32'd144000000, 32'd112000000, 32'd57600000,
    32'd57600000, 32'd0, 32'd25175000, 32'd31500000, 32'd200000000, 32'd48000000, 32'd40000000};
  localparam logic V_MX5 [NV]  = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic V_PROG [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  // hand-worked control bytes; 8'hFF means reference search only
  localparam logic [7:0] V_CTRL [NV] = '{8'h01, 8'h28, 8'h10, 8'h29, 8'h17,
    8'hFF, 8'hFF, 8'hFF, 8'h40, 8'hFF};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, max_div5 = 1'b0, prog_mode = 1'b0;
  logic [31:0] target_hz = '0;
  logic busy, done, best_post;
  logic [7:0] best_mul, ctrl_byte;
  logic [6:0] best_prediv;
  logic [2:0] best_odd_div, best_shift;
  logic [SW-1:0] best_err, achieved_hz;
  logic [31:0] pll_word;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic wd = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) wd <= 1'b1;
  end

  clk_setting_search #(.SRC_W(SW), .M_MIN(MMIN), .M_MAX(MMAX), .N_MIN(NMIN), .N_MAX(NMAX)) u_dut (
    .clk(clk), .rst(rst), .start(start), .target_hz(target_hz), .max_div5(max_div5),
    .prog_mode(prog_mode), .busy(busy), .done(done), .best_mul(best_mul),
    .best_prediv(best_prediv), .best_post(best_post), .best_odd_div(best_odd_div),
    .best_shift(best_shift), .best_err(best_err), .achieved_hz(achieved_hz),
    .ctrl_byte(ctrl_byte), .pll_word(pll_word));

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference search from the requirements
  function automatic void ref_search(input longint t, input bit mx5, input bit prog,
      output longint e_ctrl, output longint e_pll, output longint e_ach, output longint e_err);
    longint best = 999999999, bsrc = 0, bm = 0, bn = 0, bk = 0, bd = 1, bs = 0, bfix = 0;
    int nsrc = prog ? (MMAX - MMIN + 1) * (NMAX - NMIN + 1) * 2 : 2;
    for (int i = 0; i < nsrc; i++) begin
      longint src, m, n, k;
      if (prog) begin
        m = MMIN + i / ((NMAX - NMIN + 1) * 2);
        n = NMIN + (i / 2) % (NMAX - NMIN + 1);
        k = i % 2;
        src = ((64'd24000000 * m) / n) >> k;
      end else begin
        m = 0; n = 0; k = 0;
        src = (i == 0) ? 64'd288000000 : 64'd336000000;
      end
      for (int d = 1; d <= (mx5 ? 5 : 3); d += 2) begin
        for (int s = 0; s < 8; s++) begin
          longint dv = longint'(d) << s;
          longint o = (src + dv / 2) / dv;
          longint e = (o > t) ? o - t : t - o;
          if (e < best) begin
            best = e; bsrc = src; bm = m; bn = n; bk = k; bd = d; bs = s; bfix = i;
          end
        end
      end
    end
    e_err  = best;
    e_ach  = bsrc / (bd << bs);
    e_ctrl = bs | ((bd == 3) ? 8 : 0) | ((bd == 5) ? 16 : 0) |
             ((!prog && bfix == 1) ? 32 : 0) | (prog ? 64 : 0);
    e_pll  = prog ? (64'h20000 | (bk << 15) | (bn << 8) | bm) : 0;
  endfunction

  task automatic run_search(input logic [31:0] t, input logic mx5, input logic pg,
                            input bit intrude);
    @(negedge clk);
    target_hz = t; max_div5 = mx5; prog_mode = pg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", busy, 1);
    if (intrude) begin
      repeat (20) @(negedge clk);
      target_hz = t + 32'd7777777; max_div5 = ~mx5; prog_mode = ~pg; start = 1'b1;
      @(negedge clk);
      start = 1'b0; target_hz = t; max_div5 = mx5; prog_mode = pg;
    end
    while (done !== 1'b1 && !wd) @(negedge clk);
    if (wd) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
    end else begin
      chk("R9 busy low with done", busy, 0);
    end
  endtask

  task automatic check_result(input int idx, input logic [31:0] t, input logic mx5,
                              input logic pg, input logic [7:0] hand);
    longint ec, ep, ea, ee;
    ref_search(t, mx5, pg, ec, ep, ea, ee);
    chk($sformatf("R1 R2 R4 R8 ctrl v%0d", idx), ctrl_byte, ec);
    chk($sformatf("R7 pll v%0d", idx), pll_word, ep);
    chk($sformatf("R6 achieved v%0d", idx), achieved_hz, ea);
    chk($sformatf("R3 R5 err v%0d", idx), best_err, ee);
    if (hand != 8'hFF) chk($sformatf("R8 hand ctrl v%0d", idx), ctrl_byte, hand);
  endtask

  initial begin
    logic [7:0] h_ctrl;
    logic [SW-1:0] h_ach;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset ctrl", ctrl_byte, 0);
    chk("R10 reset pll", pll_word, 0);
    chk("R10 reset achieved", achieved_hz, 0);

    for (int i = 0; i < NV; i++) begin
      run_search(V_TGT[i], V_MX5[i], V_PROG[i], 1'b0);
      check_result(i, V_TGT[i], V_MX5[i], V_PROG[i], V_CTRL[i]);
      if (i == 8) begin
        chk("R2 M for 48 MHz", best_mul, 4);
        chk("R2 N for 48 MHz", best_prediv, 2);
        chk("R7 word for 48 MHz", pll_word, 32'h20204);
      end
      if (i == 2) chk("R4 divider 5 used", best_odd_div, 5);
      if (i == 3) chk("R4 limit 3 achieved", achieved_hz, 56000000);
      @(negedge clk);
      chk("R9 done one cycle", done, 0);
    end

    // R10 results hold while idle and through the next search
    h_ctrl = ctrl_byte; h_ach = achieved_hz;
    repeat (5) @(negedge clk);
    chk("R10 hold idle ctrl", ctrl_byte, h_ctrl);
    @(negedge clk);
    target_hz = 32'd65000000; max_div5 = 1'b1; prog_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R10 hold busy ctrl", ctrl_byte, h_ctrl);
    chk("R10 hold busy achieved", achieved_hz, h_ach);
    while (done !== 1'b1 && !wd) @(negedge clk);
    check_result(20, 32'd65000000, 1'b1, 1'b0, 8'hFF);

    // R9 start while busy is ignored
    run_search(32'd100000000, 1'b1, 1'b0, 1'b1);
    check_result(21, 32'd100000000, 1'b1, 1'b0, 8'hFF);

    // R1 first fixed source wins an exact 288 MHz request
    run_search(32'd288000000, 1'b0, 1'b0, 1'b0);
    chk("R1 288 source ctrl", ctrl_byte, 8'h00);
    chk("R5 zero error", best_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule